// File: doc/BRIEF.md
# General-Purpose I/O Bank with Interrupt Detection

This block manages a bank of 32 general-purpose pins behind a simple synchronous register bus. Each pin's direction is chosen per bit. The output value can be written whole, or changed one bit at a time through write-one set and clear registers, so software never needs a read-modify-write. Pin inputs pass through a two-flop synchronizer before they are read back or examined for events.

Each pin can flag an event on a low level, a high level, a rising edge or a falling edge. The four detect types are enabled separately, and several may be on at once. A detected event sets a sticky bit in the raw status of each of two interrupt lines. Every line has its own enable mask, changed through write-one set and clear addresses, and its own write-one-to-clear status. A line's interrupt output is high while any of its enabled status bits is pending. An interrupt handler reads the masked status and writes the same value back to acknowledge every pending pin in one access.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (direction register reads 0xFFFFFFFF and `pin_oe_n` is all ones), the output register reads 0, all detect and enable registers read 0, all status reads 0 and both `irq` bits are 0.
- R2: The direction register at 0x134 can be read and written. Bit n = 0 makes pin n an output and bit n = 1 makes it an input, and `pin_oe_n` always shows the register value.
- R3: The output register at 0x13C can be read and written. A write to 0x194 sets the output bits that are 1 in the write data, and a write to 0x190 clears them. Bits written as 0 keep their value, and `pin_out` shows the register value.
- R4: A read of 0x138 returns the pin levels after two synchronizer flops. Read data is registered and appears in the cycle after the read strobe. Unmapped addresses read as 0.
- R5: When bit n of the rising-detect register at 0x148 is set, a 0-to-1 change on synchronized pin n sets bit n in the raw status of both lines.
- R6: When bit n of the falling-detect register at 0x14C is set, a 1-to-0 change on synchronized pin n sets raw status bit n. Rising and falling detection may be enabled together on one pin.
- R7: The low-level register at 0x140 and the high-level register at 0x144 set raw status bit n on every cycle in which pin n is at that level. Such a bit is set again at once after a clear while the level persists.
- R8: For line k (0 or 1), a write to 0x34+4k sets the enable bits that are 1 in the write data, and a write to 0x3C+4k clears them. Both addresses read back the enable mask of that line.
- R9: For line k, raw status is read at 0x24+4k and masked status (raw AND enable) at 0x2C+4k. Writing ones to 0x2C+4k clears those raw bits of line k only. Raw bits stay set until cleared.
- R10: `irq[k]` is 1 exactly when line k has a raw status bit that is also enabled.
- R11: A pin change that matches no enabled detect type sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle after `bus_re` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value of each pin |
| pin_oe_n | output | 32 | Per-pin direction: 0 drives the pin, 1 leaves it an input |
| irq | output | 2 | Interrupt line outputs |

## Verification
The bound checker checks these on every cycle: set and clear writes always reach the output register, every detected event lands in raw status on the next edge, raw bits vanish only through a clear write, no status appears while every detect type is off, and an interrupt is never raised without an enabled bit. Other behaviour shows only through the bench's scenarios. These are the two-cycle synchronizer latency seen through a data-in read, a rising or falling change that is ignored when only the other edge is enabled, and a level bit that comes back after it is cleared. They also include the way the two lines are acknowledged independently, and a masked status that hides a raw bit that is not enabled.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int GB_W     = 32;
  localparam int GB_AW    = 9;
  localparam int GB_LINES = 2;

  typedef logic [GB_W-1:0]  gb_word_t;
  typedef logic [GB_AW-1:0] gb_addr_t;

  // Fixed register offsets (software-visible map)
  localparam gb_addr_t GB_A_RAW   = 9'h024;
  localparam gb_addr_t GB_A_MSK   = 9'h02C;
  localparam gb_addr_t GB_A_ENSET = 9'h034;
  localparam gb_addr_t GB_A_ENCLR = 9'h03C;
  localparam gb_addr_t GB_A_DIR   = 9'h134;
  localparam gb_addr_t GB_A_DIN   = 9'h138;
  localparam gb_addr_t GB_A_DOUT  = 9'h13C;
  localparam gb_addr_t GB_A_LOW   = 9'h140;
  localparam gb_addr_t GB_A_HIGH  = 9'h144;
  localparam gb_addr_t GB_A_RISE  = 9'h148;
  localparam gb_addr_t GB_A_FALL  = 9'h14C;
  localparam gb_addr_t GB_A_CLR   = 9'h190;
  localparam gb_addr_t GB_A_SET   = 9'h194;

  // Per-line register address: base plus one word per line index
  function automatic gb_addr_t gb_line_addr(gb_addr_t base, int unsigned line);
    return base + gb_addr_t'(4 * line);
  endfunction

  // Event vector from current and previous synchronized samples
  function automatic gb_word_t gb_events(gb_word_t now, gb_word_t prev,
                                         gb_word_t lo_en, gb_word_t hi_en,
                                         gb_word_t up_en, gb_word_t dn_en);
    gb_word_t lvl_lo, lvl_hi, up, dn;
    lvl_lo = ~now & lo_en;
    lvl_hi =  now & hi_en;
    up     =  now & ~prev & up_en;
    dn     = ~now &  prev & dn_en;
    return lvl_lo | lvl_hi | up | dn;
  endfunction

  // Bitwise update: clear mask applied first, set mask wins
  function automatic gb_word_t gb_w1(gb_word_t cur, gb_word_t set_m, gb_word_t clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
  import gpio_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  gb_word_t lvl,
  input  gb_word_t lo_en,
  input  gb_word_t hi_en,
  input  gb_word_t up_en,
  input  gb_word_t dn_en,
  output gb_word_t evt
);
  gb_word_t prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign evt = gb_events(lvl, prev_q, lo_en, hi_en, up_en, dn_en);
endmodule

// File: rtl/gpio_bank_irq_line.sv
module gpio_bank_irq_line
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINE = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  gb_word_t evt,
  input  logic     wr_en,
  input  gb_addr_t wr_addr,
  input  gb_word_t wr_data,
  output gb_word_t raw,
  output gb_word_t en,
  output gb_word_t clr_mask,
  output logic     irq_o
);
  localparam gb_addr_t A_MSK = gb_line_addr(GB_A_MSK,   LINE);
  localparam gb_addr_t A_ENS = gb_line_addr(GB_A_ENSET, LINE);
  localparam gb_addr_t A_ENC = gb_line_addr(GB_A_ENCLR, LINE);

  gb_word_t raw_q, en_q, en_set, en_clr;

  assign clr_mask = (wr_en && wr_addr == A_MSK) ? wr_data : '0;
  assign en_set   = (wr_en && wr_addr == A_ENS) ? wr_data : '0;
  assign en_clr   = (wr_en && wr_addr == A_ENC) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= gb_w1(raw_q, evt, clr_mask);
      en_q  <= (en_q | en_set) & ~en_clr;
    end
  end

  assign raw   = raw_q;
  assign en    = en_q;
  assign irq_o = |(raw_q & en_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GB_AW-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [GB_W-1:0]  bus_wdata,
  input  logic             bus_re,
  output logic [GB_W-1:0]  bus_rdata,
  input  logic [GB_W-1:0]  pin_in,
  output logic [GB_W-1:0]  pin_out,
  output logic [GB_W-1:0]  pin_oe_n,
  output logic [GB_LINES-1:0] irq
);
  gb_word_t dir_q, dout_q, lo_q, hi_q, up_q, dn_q;
  gb_word_t pin_s, evt;
  gb_word_t raw_s   [GB_LINES];
  gb_word_t en_s    [GB_LINES];
  gb_word_t clr_s   [GB_LINES];
  gb_word_t rd_mux;
  logic     det_any;

  // Write decode for the shared registers
  logic wr_dir, wr_dout, wr_set, wr_clr, wr_lo, wr_hi, wr_up, wr_dn;
  assign wr_dir  = bus_we && bus_addr == GB_A_DIR;
  assign wr_dout = bus_we && bus_addr == GB_A_DOUT;
  assign wr_set  = bus_we && bus_addr == GB_A_SET;
  assign wr_clr  = bus_we && bus_addr == GB_A_CLR;
  assign wr_lo   = bus_we && bus_addr == GB_A_LOW;
  assign wr_hi   = bus_we && bus_addr == GB_A_HIGH;
  assign wr_up   = bus_we && bus_addr == GB_A_RISE;
  assign wr_dn   = bus_we && bus_addr == GB_A_FALL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '1;
      dout_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      up_q   <= '0;
      dn_q   <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_dout)     dout_q <= bus_wdata;
      else if (wr_set) dout_q <= gb_w1(dout_q, bus_wdata, '0);
      else if (wr_clr) dout_q <= gb_w1(dout_q, '0, bus_wdata);
      if (wr_lo) lo_q <= bus_wdata;
      if (wr_hi) hi_q <= bus_wdata;
      if (wr_up) up_q <= bus_wdata;
      if (wr_dn) dn_q <= bus_wdata;
    end
  end

  gpio_bank_sync #(.W(GB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .q_out (pin_s)
  );

  gpio_bank_detect u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_s),
    .lo_en (lo_q),
    .hi_en (hi_q),
    .up_en (up_q),
    .dn_en (dn_q),
    .evt   (evt)
  );

  assign det_any = |(lo_q | hi_q | up_q | dn_q);

  genvar k;
  generate
    for (k = 0; k < GB_LINES; k++) begin : g_line
      gpio_bank_irq_line #(.LINE(k)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wr_en    (bus_we),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .raw      (raw_s[k]),
        .en       (en_s[k]),
        .clr_mask (clr_s[k]),
        .irq_o    (irq[k])
      );
    end
  endgenerate

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      GB_A_DIR:  rd_mux = dir_q;
      GB_A_DIN:  rd_mux = pin_s;
      GB_A_DOUT: rd_mux = dout_q;
      GB_A_LOW:  rd_mux = lo_q;
      GB_A_HIGH: rd_mux = hi_q;
      GB_A_RISE: rd_mux = up_q;
      GB_A_FALL: rd_mux = dn_q;
      default:   rd_mux = '0;
    endcase
    for (int l = 0; l < GB_LINES; l++) begin
      if (bus_addr == gb_line_addr(GB_A_RAW, l))   rd_mux = raw_s[l];
      if (bus_addr == gb_line_addr(GB_A_MSK, l))   rd_mux = raw_s[l] & en_s[l];
      if (bus_addr == gb_line_addr(GB_A_ENSET, l)) rd_mux = en_s[l];
      if (bus_addr == gb_line_addr(GB_A_ENCLR, l)) rd_mux = en_s[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign pin_out  = dout_q;
  assign pin_oe_n = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [GB_AW-1:0]    bus_addr,
  input logic [GB_W-1:0]     bus_wdata,
  input logic [GB_W-1:0]     pin_out,
  input logic [GB_W-1:0]     evt,
  input logic                det_any,
  input logic [GB_W-1:0]     raw0,
  input logic [GB_W-1:0]     raw1,
  input logic [GB_W-1:0]     en0,
  input logic [GB_W-1:0]     en1,
  input logic [GB_W-1:0]     clr0,
  input logic [GB_LINES-1:0] irq
);
  AST_SET_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == GB_A_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_CLR_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == GB_A_CLR) |=> ((pin_out & $past(bus_wdata)) == '0)); // R3

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (((raw0 & $past(evt)) == $past(evt)) && ((raw1 & $past(evt)) == $past(evt)))); // R5

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw0) & ~$past(clr0)) & ~raw0) == '0)); // R9

  AST_NO_SPURIOUS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_any) |=> (((raw0 & ~$past(raw0)) == '0) && ((raw1 & ~$past(raw1)) == '0))); // R11

  AST_IRQ0_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> ((raw0 & en0) != '0)); // R10

  AST_IRQ1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> ((raw1 & en1) != '0)); // R10
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .evt       (evt),
  .det_any   (det_any),
  .raw0      (raw_s[0]),
  .raw1      (raw_s[1]),
  .en0       (en_s[0]),
  .en1       (en_s[1]),
  .clr0      (clr_s[0]),
  .irq       (irq)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe_n;
  logic [1:0]  irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe_n  (pin_oe_n),
    .irq       (irq)
  );

  // Register offsets as given in the requirements
  localparam logic [8:0] RAW0 = 9'h024, RAW1 = 9'h028, MSK0 = 9'h02C, MSK1 = 9'h030;
  localparam logic [8:0] ENS0 = 9'h034, ENS1 = 9'h038, ENC0 = 9'h03C;
  localparam logic [8:0] DIR = 9'h134, DIN = 9'h138, DOUT = 9'h13C;
  localparam logic [8:0] LOW = 9'h140, HIGH = 9'h144, RISE = 9'h148, FALL = 9'h14C;
  localparam logic [8:0] CLRA = 9'h190, SETA = 9'h194;

  // Vector: {is_read, addr, data}; reads compare data as expected value
  localparam int NV = 17;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, DIR,  32'hFFFF_0000},
    {1'b1, DIR,  32'hFFFF_0000},   // R2
    {1'b0, DOUT, 32'h0000_00F0},
    {1'b1, DOUT, 32'h0000_00F0},   // R3
    {1'b0, SETA, 32'h0000_0F0F},
    {1'b1, DOUT, 32'h0000_0FFF},   // R3 set
    {1'b0, CLRA, 32'h0000_00A5},
    {1'b1, DOUT, 32'h0000_0F5A},   // R3 clear
    {1'b0, SETA, 32'h0000_0000},
    {1'b1, DOUT, 32'h0000_0F5A},   // R3 zeros ignored
    {1'b0, ENS0, 32'h0000_0003},
    {1'b0, ENS0, 32'h0000_0010},
    {1'b1, ENS0, 32'h0000_0013},   // R8
    {1'b0, ENC0, 32'h0000_0002},
    {1'b1, ENC0, 32'h0000_0011},   // R8
    {1'b1, ENS1, 32'h0000_0000},   // R8 line independence
    {1'b1, 9'h100, 32'h0000_0000}  // R4 unmapped
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 oe_n", pin_oe_n, 32'hFFFF_FFFF);
    check("R1 irq", {30'd0, irq}, 32'd0);
    check("R1 pin_out", pin_out, 32'd0);
    expect_reg("R1 dir", DIR, 32'hFFFF_FFFF);
    expect_reg("R1 dout", DOUT, 32'd0);
    expect_reg("R1 rise", RISE, 32'd0);
    expect_reg("R1 ens0", ENS0, 32'd0);
    expect_reg("R1 raw0", RAW0, 32'd0);

    // Register vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) expect_reg("R2/R3/R8 vector", VEC[i][40:32], VEC[i][31:0]);
      else            bus_write(VEC[i][40:32], VEC[i][31:0]);
    end
    check("R2 oe_n port", pin_oe_n, 32'hFFFF_0000);
    check("R3 pin_out port", pin_out, 32'h0000_0F5A);

    // R4 synchronizer latency: first read still sees the old level
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    bus_read(DIN, v);
    check("R4 din before sync", v, 32'd0);
    expect_reg("R4 din after sync", DIN, 32'hDEAD_BEEF);
    set_pins(32'd0);

    // Edge setup: rise on bits 0,4; fall on bits 1,4
    bus_write(RISE, 32'h11);
    bus_write(FALL, 32'h12);
    bus_write(ENC0, 32'hFFFF_FFFF);
    bus_write(ENS0, 32'h3);
    bus_write(ENS1, 32'h1);
    expect_reg("R11 raw0 idle", RAW0, 32'd0);

    set_pins(32'h1);
    expect_reg("R5 rise raw0", RAW0, 32'h1);
    expect_reg("R5 rise raw1", RAW1, 32'h1);
    check("R10 irq both", {30'd0, irq}, 32'h3);

    bus_write(MSK0, 32'h1);
    check("R9 irq after ack0", {30'd0, irq}, 32'h2);
    expect_reg("R9 raw0 cleared", RAW0, 32'd0);
    expect_reg("R9 msk1 kept", MSK1, 32'h1);
    bus_write(MSK1, 32'h1);

    set_pins(32'h3);
    expect_reg("R11 rise on fall-only pin", RAW0, 32'd0);
    check("R11 irq quiet", {30'd0, irq}, 32'd0);

    set_pins(32'h0);
    expect_reg("R6 fall raw0", RAW0, 32'h2);
    expect_reg("R9 masked hides", MSK1, 32'd0);
    check("R10 irq masked", {30'd0, irq}, 32'h1);
    bus_write(MSK0, 32'h2);
    bus_write(MSK1, 32'h2);
    expect_reg("R9 raw1 cleared", RAW1, 32'd0);

    // Both edges on bit 4
    set_pins(32'h10);
    expect_reg("R5 both rise", RAW0, 32'h10);
    bus_write(MSK0, 32'h10);
    set_pins(32'h0);
    expect_reg("R6 both fall", RAW0, 32'h10);
    bus_write(MSK0, 32'h10);
    bus_write(MSK1, 32'h10);
    bus_write(RISE, 32'h0);
    bus_write(FALL, 32'h0);

    // R7 high level persists after clear
    bus_write(HIGH, 32'h100);
    set_pins(32'h100);
    bus_write(MSK0, 32'h100);
    expect_reg("R7 high resets", RAW0, 32'h100);
    set_pins(32'h0);
    bus_write(MSK0, 32'h100);
    bus_write(MSK1, 32'h100);
    expect_reg("R7 high gone", RAW0, 32'd0);
    bus_write(HIGH, 32'h0);

    // R7 low level
    bus_write(LOW, 32'h200);
    @(negedge clk);
    expect_reg("R7 low sets", RAW0, 32'h200);
    bus_write(LOW, 32'h0);
    bus_write(MSK0, 32'h200);
    bus_write(MSK1, 32'h200);
    expect_reg("R7 low cleared", RAW0, 32'd0);
    expect_reg("R9 raw1 cleared", RAW1, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule